// File: doc/BRIEF.md
# Supervisor Call Fast-Path Dispatch Sequencer

After a supervisor-call interrupt, this block decides whether the call can be serviced on a fast path. If it can, it performs the dispatch itself. On a start pulse it captures a snapshot of its inputs. The snapshot covers the saved interrupt status, the space identifiers, the task lock and screening state, the per-call table entry, and the operand and address words it may load. It then applies a shared eligibility gate, followed by a rule that depends on the call type. Type 1 calls request a local lock from an external lock unit. Types 2, 3 and 4 request a block from an external pool unit. Type 6 calls proceed directly. Any other type is never serviced.

On the fast path the sequencer works through four phases in order. It copies the saved status words into the current request block. It saves all general registers to a save area in ascending order. It reloads a fixed set of registers. Finally it signals an instruction-address load with the value given to register 9. When the call is not eligible, the block finishes with a single done pulse and writes nothing. The lock unit and the pool unit are outside the block and answer with done/ok strobes.

Top module: `svc_assist_seq`

## Requirements
- R1: The fast path is refused unless interrupts were enabled before the call, the task holds no locks, and call screening is off.
- R2: The fast path is refused unless the primary and secondary space identifiers both equal the dispatched space identifier and the saved status specifies primary-space mode.
- R3: A type 1 call is serviced only if it is assistable, its lock-need field is 01 (local lock only), and the lock unit answers lock_done with lock_ok=1. lock_req is raised only for an eligible type 1 call.
- R4: A type 2, 3 or 4 call is serviced only if it is assistable and the pool unit answers pool_done with pool_ok=1. pool_req is raised only for an eligible call of these types.
- R5: A type 6 call is serviced only if it is assistable and its lock-need field is 00. Any type other than 1, 2, 3, 4 and 6 is never serviced.
- R6: A refused call completes with one done pulse and assisted=0. It makes no request-block, save-area or register write, and it raises no instruction-address load.
- R7: On the fast path, status words 0 to STATUS_WORDS-1 are written to request-block slots 0 to STATUS_WORDS-1, one per cycle in ascending order, before any register is saved.
- R8: On the fast path, registers 0 to 15 are written to save-area slots 0 to 15 in ascending order, with their values from before the call. All of these saves complete before any register is reloaded.
- R9: On the fast path the register loads are as follows. Register 3 gets vector_addr. Register 4 gets operand2. Register 6 gets call_entry_point. Register 7 gets operand1. Register 12 gets call_entry_addr. Register 9 gets the entry address for the call's class and register 14 gets the exit address for that class. The classes are type 1 (index 0), types 2–4 (index 1) and type 6 (index 2). No other register changes, apart from those named in R10.
- R10: Register 5 gets current_rb for types 1 and 6, or pool_block for types 2–4. Register 11 gets pool_subarea for types 2–4 only and is left unchanged for types 1 and 6.
- R11: When a fast-path call completes, ia_load is high together with done and assisted, and ia_value equals the value loaded into register 9.
- R12: The call-table entry is decoded from fixed bit fields. The call type is bits 3:0, the assistable flag is bit 7, and the lock need is bits 9:8. A cleared assistable flag refuses the call.
- R13: After reset, busy and done are low. done is a one-cycle pulse, after which the block is idle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluating the latest call; the inputs below are captured here |
| irq_was_enabled | input | 1 | Interrupts were enabled before the call |
| task_holds_lock | input | 1 | Dispatched task holds some lock |
| screening_on | input | 1 | Call screening is active for the task |
| old_psw_primary | input | 1 | Saved status word specifies primary-space mode |
| primary_space | input | SPACE_W | Primary space identifier |
| secondary_space | input | SPACE_W | Secondary space identifier |
| dispatched_space | input | SPACE_W | Dispatched space identifier |
| call_entry | input | 32 | Call-table entry word |
| call_entry_addr | input | W | Address of the call-table entry |
| call_entry_point | input | W | Entry point of the call routine |
| vector_addr | input | W | System vector address |
| operand1 | input | W | First operand word |
| operand2 | input | W | Second operand word |
| current_rb | input | W | Current request block address |
| entry_by_class | input | 3*W | Fast-path entry address per class |
| exit_by_class | input | 3*W | Fast-path exit address per class |
| svc_status | input | STATUS_WORDS*W | Saved interrupt status words |
| lock_req | output | 1 | Request for the local lock |
| lock_done | input | 1 | Lock unit answer strobe |
| lock_ok | input | 1 | Lock granted, qualified by lock_done |
| pool_req | output | 1 | Request for a pooled block |
| pool_done | input | 1 | Pool unit answer strobe |
| pool_ok | input | 1 | Block granted, qualified by pool_done |
| pool_block | input | W | Granted block address |
| pool_subarea | input | W | Granted block sub-area address |
| gr_rd_idx | output | GIDX_W | Register read index |
| gr_rd_data | input | W | Register read data, same cycle |
| save_we | output | 1 | Save-area write enable |
| save_idx | output | GIDX_W | Save-area slot |
| save_data | output | W | Save-area write data |
| rb_we | output | 1 | Request-block write enable |
| rb_idx | output | SIDX_W | Request-block status slot |
| rb_data | output | W | Request-block write data |
| gr_we | output | 1 | Register write enable |
| gr_idx | output | GIDX_W | Register write index |
| gr_data | output | W | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| assisted | output | 1 | Fast path taken, valid with done |
| ia_load | output | 1 | Load instruction address |
| ia_value | output | W | New instruction address |

## Verification
The assertions check the ordering rules on every cycle. Saves ascend, no register is reloaded before the last save, and a refused call ends without any write. They also check that lock and pool requests appear only for eligible calls of the right class, that done is a single pulse, and that ia_value matches the last value given to register 9. Only the bench scenarios can show that the eligibility decision is right for each gate and type, and that every register, save slot and request-block word ends up with the right value. The bench covers each refusal cause, lock and pool denial, and both register-5/register-11 variants.

// File: rtl/svc_assist_pkg.sv
package svc_assist_pkg;

    localparam int unsigned ENTRY_W      = 32;
    localparam int unsigned TYPE_LSB     = 0;
    localparam int unsigned TYPE_W       = 4;
    localparam int unsigned ASSIST_BIT   = 7;
    localparam int unsigned NEED_LSB     = 8;
    localparam int unsigned NCLASS       = 3;
    localparam int unsigned LOAD_STEPS   = 9;
    localparam int unsigned SUBAREA_STEP = 6;

    typedef enum logic [1:0] {
        CLS_T1   = 2'd0,
        CLS_T234 = 2'd1,
        CLS_T6   = 2'd2,
        CLS_NONE = 2'd3
    } svc_class_e;

    typedef enum logic [1:0] {
        NEED_NONE  = 2'b00,
        NEED_LOCAL = 2'b01,
        NEED_OTHER = 2'b10,
        NEED_MIXED = 2'b11
    } lock_need_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT_LOCK,
        ST_WAIT_POOL,
        ST_COPY,
        ST_SAVE,
        ST_LOAD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [TYPE_W-1:0] svc_type;
        logic              assistable;
        lock_need_e        lock_need;
    } tbl_fields_t;

    function automatic tbl_fields_t decode_entry(input logic [ENTRY_W-1:0] e);
        tbl_fields_t f;
        f.svc_type   = e[TYPE_LSB +: TYPE_W];
        f.assistable = e[ASSIST_BIT];
        f.lock_need  = lock_need_e'(e[NEED_LSB +: 2]);
        return f;
    endfunction

    function automatic svc_class_e class_of(input logic [TYPE_W-1:0] t);
        case (t)
            4'd1:             return CLS_T1;
            4'd2, 4'd3, 4'd4: return CLS_T234;
            4'd6:             return CLS_T6;
            default:          return CLS_NONE;
        endcase
    endfunction

    // Register written at each load step, ascending.
    function automatic logic [3:0] load_target(input logic [3:0] step);
        case (step)
            4'd0:    return 4'd3;
            4'd1:    return 4'd4;
            4'd2:    return 4'd5;
            4'd3:    return 4'd6;
            4'd4:    return 4'd7;
            4'd5:    return 4'd9;
            4'd6:    return 4'd11;
            4'd7:    return 4'd12;
            default: return 4'd14;
        endcase
    endfunction

endpackage

// File: rtl/svc_elig_check.sv
module svc_elig_check
    import svc_assist_pkg::*;
#(
    parameter int unsigned SPACE_W = 16
) (
    input  logic               irq_was_enabled,
    input  logic               task_holds_lock,
    input  logic               screening_on,
    input  logic               old_psw_primary,
    input  logic [SPACE_W-1:0] primary_space,
    input  logic [SPACE_W-1:0] secondary_space,
    input  logic [SPACE_W-1:0] dispatched_space,
    input  tbl_fields_t        fields,
    output svc_class_e         cls,
    output logic               eligible
);

    logic env_ok;
    logic space_ok;
    logic type_ok;

    always_comb begin
        env_ok   = irq_was_enabled && !task_holds_lock && !screening_on;
        space_ok = (primary_space == dispatched_space) &&
                   (secondary_space == dispatched_space) && old_psw_primary;
        cls      = class_of(fields.svc_type);
        case (cls)
            CLS_T1:   type_ok = (fields.lock_need == NEED_LOCAL);
            CLS_T234: type_ok = 1'b1;
            CLS_T6:   type_ok = (fields.lock_need == NEED_NONE);
            default:  type_ok = 1'b0;
        endcase
        eligible = env_ok && space_ok && fields.assistable && type_ok;
    end

endmodule

// File: rtl/svc_reg_loader.sv
module svc_reg_loader
    import svc_assist_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [3:0]          step,
    input  svc_class_e          cls,
    input  logic [W-1:0]        vector_addr,
    input  logic [W-1:0]        operand1,
    input  logic [W-1:0]        operand2,
    input  logic [W-1:0]        current_rb,
    input  logic [W-1:0]        call_entry_point,
    input  logic [W-1:0]        call_entry_addr,
    input  logic [W-1:0]        pool_block,
    input  logic [W-1:0]        pool_subarea,
    input  logic [NCLASS*W-1:0] entry_by_class,
    input  logic [NCLASS*W-1:0] exit_by_class,
    output logic [3:0]          target,
    output logic [W-1:0]        data,
    output logic [W-1:0]        entry_sel
);

    localparam int unsigned CIDX_W = $clog2(NCLASS);

    logic [W-1:0]        entry_arr [NCLASS];
    logic [W-1:0]        exit_arr  [NCLASS];
    logic [CIDX_W-1:0]   cidx;
    logic [W-1:0]        exit_sel;

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        assign entry_arr[c] = entry_by_class[c*W +: W];
        assign exit_arr[c]  = exit_by_class[c*W +: W];
    end

    always_comb begin
        cidx      = (cls == CLS_NONE) ? '0 : CIDX_W'(cls);
        entry_sel = entry_arr[cidx];
        exit_sel  = exit_arr[cidx];
        target    = load_target(step);
        case (step)
            4'd0:    data = vector_addr;
            4'd1:    data = operand2;
            4'd2:    data = (cls == CLS_T234) ? pool_block : current_rb;
            4'd3:    data = call_entry_point;
            4'd4:    data = operand1;
            4'd5:    data = entry_sel;
            4'd6:    data = pool_subarea;
            4'd7:    data = call_entry_addr;
            default: data = exit_sel;
        endcase
    end

endmodule

// File: rtl/svc_seq_ctrl.sv
module svc_seq_ctrl
    import svc_assist_pkg::*;
#(
    parameter int unsigned STATUS_WORDS = 4,
    parameter int unsigned NGR          = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       eligible,
    input  svc_class_e cls,
    input  logic       lock_done,
    input  logic       lock_ok,
    input  logic       pool_done,
    input  logic       pool_ok,
    output logic       start_accept,
    output logic       busy,
    output logic       done,
    output logic       assisted,
    output logic       lock_req,
    output logic       pool_req,
    output logic       pool_take,
    output logic       copy_we,
    output logic       save_we,
    output logic       load_we,
    output logic [$clog2(STATUS_WORDS)-1:0] copy_idx,
    output logic [$clog2(NGR)-1:0]          save_idx,
    output logic [3:0]                      load_step
);

    localparam int unsigned SIDX_W = $clog2(STATUS_WORDS);
    localparam int unsigned GIDX_W = $clog2(NGR);
    localparam int unsigned MAX_A  = (STATUS_WORDS > NGR) ? STATUS_WORDS : NGR;
    localparam int unsigned MAX_N  = (MAX_A > LOAD_STEPS) ? MAX_A : LOAD_STEPS;
    localparam int unsigned CNT_W  = $clog2(MAX_N + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             assist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            assist_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_EVAL;
                        assist_q <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    cnt <= '0;
                    if (!eligible) begin
                        state <= ST_DONE;
                    end else begin
                        case (cls)
                            CLS_T1:   state <= ST_WAIT_LOCK;
                            CLS_T234: state <= ST_WAIT_POOL;
                            CLS_T6:   state <= ST_COPY;
                            default:  state <= ST_DONE;
                        endcase
                    end
                end
                ST_WAIT_LOCK: begin
                    if (lock_done) state <= lock_ok ? ST_COPY : ST_DONE;
                end
                ST_WAIT_POOL: begin
                    if (pool_done) state <= pool_ok ? ST_COPY : ST_DONE;
                end
                ST_COPY: begin
                    if (cnt == CNT_W'(STATUS_WORDS - 1)) begin
                        cnt   <= '0;
                        state <= ST_SAVE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SAVE: begin
                    if (cnt == CNT_W'(NGR - 1)) begin
                        cnt   <= '0;
                        state <= ST_LOAD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (cnt == CNT_W'(LOAD_STEPS - 1)) begin
                        assist_q <= 1'b1;
                        state    <= ST_DONE;
                    end else if (cnt == CNT_W'(SUBAREA_STEP - 1) && cls != CLS_T234) begin
                        cnt <= cnt + CNT_W'(2);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        start_accept = (state == ST_IDLE) && start;
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        assisted     = done && assist_q;
        lock_req     = (state == ST_WAIT_LOCK);
        pool_req     = (state == ST_WAIT_POOL);
        pool_take    = (state == ST_WAIT_POOL) && pool_done && pool_ok;
        copy_we      = (state == ST_COPY);
        save_we      = (state == ST_SAVE);
        load_we      = (state == ST_LOAD);
        copy_idx     = cnt[SIDX_W-1:0];
        save_idx     = cnt[GIDX_W-1:0];
        load_step    = cnt[3:0];
    end

    // R3
    lock_req_scope_chk: assert property (@(posedge clk) disable iff (rst)
        lock_req |-> (cls == CLS_T1) && eligible);

    // R4
    pool_req_scope_chk: assert property (@(posedge clk) disable iff (rst)
        pool_req |-> (cls == CLS_T234) && eligible);

    // R8
    save_ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (save_we && $past(save_we)) |-> (save_idx == $past(save_idx) + 1'b1));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: rtl/svc_assist_seq.sv
module svc_assist_seq
    import svc_assist_pkg::*;
#(
    parameter int unsigned W            = 32,
    parameter int unsigned SPACE_W      = 16,
    parameter int unsigned STATUS_WORDS = 4,
    parameter int unsigned NGR          = 16,
    localparam int unsigned GIDX_W      = $clog2(NGR),
    localparam int unsigned SIDX_W      = $clog2(STATUS_WORDS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      irq_was_enabled,
    input  logic                      task_holds_lock,
    input  logic                      screening_on,
    input  logic                      old_psw_primary,
    input  logic [SPACE_W-1:0]        primary_space,
    input  logic [SPACE_W-1:0]        secondary_space,
    input  logic [SPACE_W-1:0]        dispatched_space,
    input  logic [ENTRY_W-1:0]        call_entry,
    input  logic [W-1:0]              call_entry_addr,
    input  logic [W-1:0]              call_entry_point,
    input  logic [W-1:0]              vector_addr,
    input  logic [W-1:0]              operand1,
    input  logic [W-1:0]              operand2,
    input  logic [W-1:0]              current_rb,
    input  logic [NCLASS*W-1:0]       entry_by_class,
    input  logic [NCLASS*W-1:0]       exit_by_class,
    input  logic [STATUS_WORDS*W-1:0] svc_status,
    output logic                      lock_req,
    input  logic                      lock_done,
    input  logic                      lock_ok,
    output logic                      pool_req,
    input  logic                      pool_done,
    input  logic                      pool_ok,
    input  logic [W-1:0]              pool_block,
    input  logic [W-1:0]              pool_subarea,
    output logic [GIDX_W-1:0]         gr_rd_idx,
    input  logic [W-1:0]              gr_rd_data,
    output logic                      save_we,
    output logic [GIDX_W-1:0]         save_idx,
    output logic [W-1:0]              save_data,
    output logic                      rb_we,
    output logic [SIDX_W-1:0]         rb_idx,
    output logic [W-1:0]              rb_data,
    output logic                      gr_we,
    output logic [GIDX_W-1:0]         gr_idx,
    output logic [W-1:0]              gr_data,
    output logic                      busy,
    output logic                      done,
    output logic                      assisted,
    output logic                      ia_load,
    output logic [W-1:0]              ia_value
);

    // Captured call context
    logic                      c_irq_en, c_locked, c_screen, c_primary;
    logic [SPACE_W-1:0]        c_pri, c_sec, c_disp;
    logic [ENTRY_W-1:0]        c_entry;
    logic [W-1:0]              c_entry_addr, c_entry_point, c_vector;
    logic [W-1:0]              c_op1, c_op2, c_rb;
    logic [NCLASS*W-1:0]       c_entries, c_exits;
    logic [W-1:0]              c_status [STATUS_WORDS];
    logic [W-1:0]              c_pool_blk, c_pool_sub;

    logic        start_accept, pool_take, copy_we, load_we;
    logic        eligible;
    svc_class_e  cls;
    tbl_fields_t fields;
    logic [3:0]  load_step;
    logic [3:0]  load_tgt;
    logic [W-1:0] load_data;
    logic [GIDX_W-1:0] save_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_irq_en  <= 1'b0;
            c_locked  <= 1'b0;
            c_screen  <= 1'b0;
            c_primary <= 1'b0;
            c_entry   <= '0;
        end else if (start_accept) begin
            c_irq_en      <= irq_was_enabled;
            c_locked      <= task_holds_lock;
            c_screen      <= screening_on;
            c_primary     <= old_psw_primary;
            c_entry       <= call_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (start_accept) begin
            c_pri         <= primary_space;
            c_sec         <= secondary_space;
            c_disp        <= dispatched_space;
            c_entry_addr  <= call_entry_addr;
            c_entry_point <= call_entry_point;
            c_vector      <= vector_addr;
            c_op1         <= operand1;
            c_op2         <= operand2;
            c_rb          <= current_rb;
            c_entries     <= entry_by_class;
            c_exits       <= exit_by_class;
        end
        if (pool_take) begin
            c_pool_blk <= pool_block;
            c_pool_sub <= pool_subarea;
        end
    end

    for (genvar s = 0; s < STATUS_WORDS; s++) begin : g_status
        always_ff @(posedge clk) begin
            if (start_accept) c_status[s] <= svc_status[s*W +: W];
        end
    end

    assign fields = decode_entry(c_entry);

    svc_elig_check #(.SPACE_W(SPACE_W)) u_elig (
        .irq_was_enabled  (c_irq_en),
        .task_holds_lock  (c_locked),
        .screening_on     (c_screen),
        .old_psw_primary  (c_primary),
        .primary_space    (c_pri),
        .secondary_space  (c_sec),
        .dispatched_space (c_disp),
        .fields           (fields),
        .cls              (cls),
        .eligible         (eligible)
    );

    svc_seq_ctrl #(.STATUS_WORDS(STATUS_WORDS), .NGR(NGR)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .eligible     (eligible),
        .cls          (cls),
        .lock_done    (lock_done),
        .lock_ok      (lock_ok),
        .pool_done    (pool_done),
        .pool_ok      (pool_ok),
        .start_accept (start_accept),
        .busy         (busy),
        .done         (done),
        .assisted     (assisted),
        .lock_req     (lock_req),
        .pool_req     (pool_req),
        .pool_take    (pool_take),
        .copy_we      (copy_we),
        .save_we      (save_we),
        .load_we      (load_we),
        .copy_idx     (rb_idx),
        .save_idx     (save_slot),
        .load_step    (load_step)
    );

    svc_reg_loader #(.W(W)) u_loader (
        .step             (load_step),
        .cls              (cls),
        .vector_addr      (c_vector),
        .operand1         (c_op1),
        .operand2         (c_op2),
        .current_rb       (c_rb),
        .call_entry_point (c_entry_point),
        .call_entry_addr  (c_entry_addr),
        .pool_block       (c_pool_blk),
        .pool_subarea     (c_pool_sub),
        .entry_by_class   (c_entries),
        .exit_by_class    (c_exits),
        .target           (load_tgt),
        .data             (load_data),
        .entry_sel        (ia_value)
    );

    always_comb begin
        rb_we     = copy_we;
        rb_data   = c_status[rb_idx];
        save_idx  = save_slot;
        gr_rd_idx = save_slot;
        save_data = gr_rd_data;
        gr_we     = load_we;
        gr_idx    = GIDX_W'(load_tgt);
        gr_data   = load_data;
        ia_load   = assisted;
    end

    // Checker state, observed at the block's write ports
    logic         saves_complete;
    logic         wrote_any;
    logic [W-1:0] r9_last;

    always_ff @(posedge clk) begin
        if (rst || start_accept) begin
            saves_complete <= 1'b0;
            wrote_any      <= 1'b0;
        end else begin
            if (save_we && save_idx == GIDX_W'(NGR - 1)) saves_complete <= 1'b1;
            if (save_we || rb_we || gr_we) wrote_any <= 1'b1;
        end
        if (gr_we && gr_idx == GIDX_W'(9)) r9_last <= gr_data;
    end

    // R8
    reload_after_save_chk: assert property (@(posedge clk) disable iff (rst)
        gr_we |-> saves_complete);

    // R7
    copy_before_save_chk: assert property (@(posedge clk) disable iff (rst)
        rb_we |-> !saves_complete && !gr_we && !save_we);

    // R6
    noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !assisted) |-> (!wrote_any && !ia_load));

    // R11
    ia_from_r9_chk: assert property (@(posedge clk) disable iff (rst)
        ia_load |-> (ia_value == r9_last) && saves_complete);

endmodule

// File: tb/tb_svc_assist_seq.sv
module tb_svc_assist_seq;
    import svc_assist_pkg::*;

    localparam int unsigned W   = 32;
    localparam int unsigned SPW = 16;
    localparam int unsigned SW  = 4;
    localparam int unsigned NGR = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic irq_was_enabled, task_holds_lock, screening_on, old_psw_primary;
    logic [SPW-1:0] primary_space, secondary_space, dispatched_space;
    logic [31:0]    call_entry;
    logic [W-1:0]   call_entry_addr, call_entry_point, vector_addr;
    logic [W-1:0]   operand1, operand2, current_rb;
    logic [3*W-1:0] entry_by_class, exit_by_class;
    logic [SW*W-1:0] svc_status;
    logic lock_req, pool_req;
    logic lock_done = 1'b0, lock_ok = 1'b0, pool_done = 1'b0, pool_ok = 1'b0;
    logic [W-1:0] pool_block, pool_subarea;
    logic [3:0]   gr_rd_idx, save_idx, gr_idx;
    logic [1:0]   rb_idx;
    logic [W-1:0] save_data, rb_data, gr_data, ia_value, gr_rd_data;
    logic save_we, rb_we, gr_we, busy, done, assisted, ia_load;

    logic [W-1:0] gr_model [NGR];
    assign gr_rd_data = gr_model[gr_rd_idx];

    svc_assist_seq #(.W(W), .SPACE_W(SPW), .STATUS_WORDS(SW), .NGR(NGR)) dut (
        .clk(clk), .rst(rst), .start(start),
        .irq_was_enabled(irq_was_enabled), .task_holds_lock(task_holds_lock),
        .screening_on(screening_on), .old_psw_primary(old_psw_primary),
        .primary_space(primary_space), .secondary_space(secondary_space),
        .dispatched_space(dispatched_space), .call_entry(call_entry),
        .call_entry_addr(call_entry_addr), .call_entry_point(call_entry_point),
        .vector_addr(vector_addr), .operand1(operand1), .operand2(operand2),
        .current_rb(current_rb), .entry_by_class(entry_by_class),
        .exit_by_class(exit_by_class), .svc_status(svc_status),
        .lock_req(lock_req), .lock_done(lock_done), .lock_ok(lock_ok),
        .pool_req(pool_req), .pool_done(pool_done), .pool_ok(pool_ok),
        .pool_block(pool_block), .pool_subarea(pool_subarea),
        .gr_rd_idx(gr_rd_idx), .gr_rd_data(gr_rd_data),
        .save_we(save_we), .save_idx(save_idx), .save_data(save_data),
        .rb_we(rb_we), .rb_idx(rb_idx), .rb_data(rb_data),
        .gr_we(gr_we), .gr_idx(gr_idx), .gr_data(gr_data),
        .busy(busy), .done(done), .assisted(assisted),
        .ia_load(ia_load), .ia_value(ia_value)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit lock_grant, pool_grant;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL R13 watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Expected decision and the requirement that decides it.
    function automatic bit exp_assist(output string tag);
        logic [3:0] t;
        logic       asst;
        logic [1:0] need;
        t    = call_entry[3:0];
        asst = call_entry[7];
        need = call_entry[9:8];
        if (!irq_was_enabled || task_holds_lock || screening_on) begin
            tag = "R1"; return 1'b0;
        end
        if (primary_space != dispatched_space || secondary_space != dispatched_space ||
            !old_psw_primary) begin
            tag = "R2"; return 1'b0;
        end
        if (!asst) begin
            tag = "R12"; return 1'b0;
        end
        if (t == 4'd1) begin
            tag = "R3"; return (need == 2'b01) && lock_grant;
        end
        if (t == 4'd2 || t == 4'd3 || t == 4'd4) begin
            tag = "R4"; return pool_grant;
        end
        tag = "R5";
        return (t == 4'd6) && (need == 2'b00);
    endfunction

    task automatic randomize_inputs(input bit bad_gates);
        int r;
        logic [3:0] t;
        irq_was_enabled  = !(bad_gates && ($urandom % 8 == 0));
        task_holds_lock  = bad_gates && ($urandom % 8 == 0);
        screening_on     = bad_gates && ($urandom % 8 == 0);
        old_psw_primary  = !(bad_gates && ($urandom % 8 == 0));
        dispatched_space = SPW'($urandom);
        primary_space    = (bad_gates && ($urandom % 8 == 0)) ? SPW'($urandom) : dispatched_space;
        secondary_space  = (bad_gates && ($urandom % 8 == 0)) ? SPW'($urandom) : dispatched_space;
        r = $urandom % 10;
        case (r)
            0, 1:    t = 4'd1;
            2:       t = 4'd2;
            3:       t = 4'd3;
            4:       t = 4'd4;
            5, 6:    t = 4'd6;
            default: t = 4'($urandom);
        endcase
        call_entry       = $urandom;
        call_entry[3:0]  = t;
        call_entry[7]    = ($urandom % 6 != 0);
        call_entry[9:8]  = (t == 4'd1) ? (($urandom % 4 == 0) ? 2'($urandom) : 2'b01)
                                       : (($urandom % 4 == 0) ? 2'($urandom) : 2'b00);
        call_entry_addr  = $urandom;
        call_entry_point = $urandom;
        vector_addr      = $urandom;
        operand1         = $urandom;
        operand2         = $urandom;
        current_rb       = $urandom;
        pool_block       = $urandom;
        pool_subarea     = $urandom;
        for (int c = 0; c < 3; c++) begin
            entry_by_class[c*W +: W] = $urandom;
            exit_by_class[c*W +: W]  = $urandom;
        end
        for (int s = 0; s < SW; s++) svc_status[s*W +: W] = $urandom;
        for (int g = 0; g < NGR; g++) gr_model[g] = $urandom;
        lock_grant = ($urandom % 4 != 0);
        pool_grant = ($urandom % 4 != 0);
    endtask

    task automatic set_good(input logic [3:0] t, input logic [1:0] need);
        randomize_inputs(1'b0);
        call_entry[3:0] = t;
        call_entry[7]   = 1'b1;
        call_entry[9:8] = need;
        lock_grant = 1'b1;
        pool_grant = 1'b1;
    endtask

    task automatic run_case();
        logic [W-1:0] orig [NGR];
        logic [W-1:0] expv [NGR];
        logic [W-1:0] rb_seen [SW];
        int  n_rb, n_save, n_gr, first_gr, last_save, last_rb, first_save, k, wait_cnt;
        bit  saw_done, got_assist, got_ia, save_ok, save_order_ok, exp_a, seen_start;
        bit  is234;
        int  cidx;
        logic [W-1:0] got_iav;
        string tag;
        logic [3:0] t;
        for (int g = 0; g < NGR; g++) orig[g] = gr_model[g];
        n_rb = 0; n_save = 0; n_gr = 0; first_gr = -1; last_save = -1; last_rb = -1;
        first_save = -1; saw_done = 0; save_ok = 1; save_order_ok = 1; got_assist = 0;
        got_ia = 0; got_iav = '0; seen_start = 0;
        wait_cnt = $urandom % 3;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        k = 0;
        while (!saw_done && k < 100) begin
            if (rb_we) begin
                if (n_rb < SW) rb_seen[n_rb] = rb_data;
                if (32'(rb_idx) != n_rb) save_order_ok = 0;
                n_rb++; last_rb = k;
            end
            if (save_we) begin
                if (32'(save_idx) != n_save) save_order_ok = 0;
                if (n_save < NGR && save_data != orig[n_save]) save_ok = 0;
                if (first_save < 0) first_save = k;
                n_save++; last_save = k;
            end
            if (gr_we) begin
                if (first_gr < 0) first_gr = k;
                gr_model[gr_idx] = gr_data;
                n_gr++;
            end
            if (done) begin
                saw_done = 1; got_assist = assisted; got_ia = ia_load; got_iav = ia_value;
            end
            if (lock_done) lock_done = 1'b0;
            else if (lock_req) begin
                if (wait_cnt == 0) begin lock_done = 1'b1; lock_ok = lock_grant; end
                else wait_cnt--;
            end
            if (pool_done) pool_done = 1'b0;
            else if (pool_req) begin
                if (wait_cnt == 0) begin pool_done = 1'b1; pool_ok = pool_grant; end
                else wait_cnt--;
            end
            k++;
            @(negedge clk);
        end
        lock_done = 1'b0; pool_done = 1'b0;
        check(saw_done, "R13", "done seen", W'(saw_done), 1);
        check(!done && !busy, "R13", "done single pulse then idle", W'({done, busy}), 0);
        exp_a = exp_assist(tag);
        check(got_assist == exp_a, tag, "assist decision", W'(got_assist), W'(exp_a));
        t = call_entry[3:0];
        is234 = (t == 4'd2 || t == 4'd3 || t == 4'd4);
        cidx = (t == 4'd1) ? 0 : (is234 ? 1 : 2);
        for (int g = 0; g < NGR; g++) expv[g] = orig[g];
        if (exp_a) begin
            expv[3]  = vector_addr;
            expv[4]  = operand2;
            expv[5]  = is234 ? pool_block : current_rb;
            expv[6]  = call_entry_point;
            expv[7]  = operand1;
            expv[9]  = entry_by_class[cidx*W +: W];
            if (is234) expv[11] = pool_subarea;
            expv[12] = call_entry_addr;
            expv[14] = exit_by_class[cidx*W +: W];
            check(n_rb == SW, "R7", "status word count", W'(n_rb), W'(SW));
            for (int s = 0; s < SW; s++)
                if (s < n_rb)
                    check(rb_seen[s] == svc_status[s*W +: W], "R7", "status word",
                          rb_seen[s], svc_status[s*W +: W]);
            check(last_rb < first_save, "R7", "status copy before saves",
                  W'(last_rb), W'(first_save));
            check(n_save == NGR && save_ok && save_order_ok, "R8", "saves ascending with old values",
                  W'(n_save), W'(NGR));
            check(first_gr > last_save, "R8", "reload after last save",
                  W'(first_gr), W'(last_save + 1));
            for (int g = 0; g < NGR; g++)
                check(gr_model[g] == expv[g], (g == 5 || g == 11) ? "R10" : "R9",
                      $sformatf("register %0d", g), gr_model[g], expv[g]);
            check(got_ia && got_iav == expv[9], "R11", "instruction address from register 9",
                  got_iav, expv[9]);
        end else begin
            check(n_rb == 0 && n_save == 0 && n_gr == 0, "R6", "no writes on refusal",
                  W'(n_rb + n_save + n_gr), 0);
            check(!got_ia, "R6", "no address load on refusal", W'(got_ia), 0);
            for (int g = 0; g < NGR; g++)
                check(gr_model[g] == orig[g], "R6", $sformatf("register %0d kept", g),
                      gr_model[g], orig[g]);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        randomize_inputs(1'b0);
        repeat (3) @(negedge clk);
        check(!busy && !done && !assisted, "R13", "reset state", W'({busy, done, assisted}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R13", "idle after reset", W'({busy, done}), 0);

        // Directed corner cases
        set_good(4'd1, 2'b01); run_case();                               // R3 granted
        set_good(4'd1, 2'b01); lock_grant = 1'b0; run_case();            // R3 lock denied
        set_good(4'd1, 2'b10); run_case();                               // R3 other lock need
        set_good(4'd3, 2'b11); run_case();                               // R4 granted
        set_good(4'd4, 2'b00); pool_grant = 1'b0; run_case();            // R4 pool denied
        set_good(4'd6, 2'b00); run_case();                               // R5 serviced
        set_good(4'd6, 2'b01); run_case();                               // R5 needs a lock
        set_good(4'd5, 2'b00); run_case();                               // R5 unsupported type
        set_good(4'd6, 2'b00); call_entry[7] = 1'b0; run_case();         // R12 not assistable
        set_good(4'd2, 2'b00); irq_was_enabled = 1'b0; run_case();       // R1
        set_good(4'd2, 2'b00); task_holds_lock = 1'b1; run_case();       // R1
        set_good(4'd6, 2'b00); screening_on = 1'b1; run_case();          // R1
        set_good(4'd6, 2'b00); secondary_space = ~dispatched_space; run_case(); // R2
        set_good(4'd1, 2'b01); old_psw_primary = 1'b0; run_case();       // R2

        // R13: start while busy is ignored (second start pulse mid-sequence)
        set_good(4'd6, 2'b00);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        begin
            int n_done = 0;
            for (int i = 0; i < 60; i++) begin
                if (done) n_done++;
                @(negedge clk);
            end
            check(n_done == 1, "R13", "start while busy ignored", W'(n_done), 1);
        end

        for (int i = 0; i < 300; i++) begin
            randomize_inputs(1'b1);
            run_case();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule